// File: doc/BRIEF.md
# Write-protect command sequence guard

This block sits between the decoded write strobes of a byte-wide non-volatile memory and its storage array. Every qualified write (one cycle of `wr_valid` with an address and a data byte) is classified against a small set of command patterns. The block then decides whether that write may be programmed. The decision comes out one cycle later, with the address and data of the write, so the array can act on it directly.

The block keeps a protection flag, which is clear after reset. The flag is set when a three-write unlock prefix is followed by one ordinary data write. While the flag is set, only a write that directly follows a fresh unlock prefix is let through. Every other write is refused. A six-write disable sequence clears the flag.

The command writes themselves are never programmed: the prefix's closing write, and every write from the third step of the disable sequence onward. When protection is off, a write that only starts a command pattern and does not complete it is treated as an ordinary write.

Top module: `sdp_seq_guard`

## Requirements
- R1: After reset, `prot_on` is 0 and `dec_valid` is 0.
- R2: Each cycle with `wr_valid` high produces exactly one cycle of `dec_valid` on the next cycle. That cycle carries the write's address on `dec_addr` and its data on `dec_data`. No `dec_valid` appears without a write, and `dec_pass` is only high together with `dec_valid`.
- R3: With protection off, a write that matches no command pattern is passed (`dec_pass`=1).
- R4: The unlock prefix is data 0xAA at 0x5555, then 0x55 at 0x2AAA, then 0xA0 at 0x5555. The 0xA0 write is refused. The next write of any kind is passed, and `prot_on` becomes 1 in the same cycle as its decision.
- R5: The unlock prefix alone leaves `prot_on` unchanged. `prot_on` only changes in the decision cycle of a write.
- R6: With protection on, a write that does not directly follow a complete unlock prefix is refused.
- R7: With protection on, a complete prefix lets exactly one following write through. The write after that is refused again.
- R8: The disable sequence is 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555. Writes three to six are refused in either protection state. The 0x20 write clears `prot_on`, and later ordinary writes pass.
- R9: A write that does not fit the expected next step sends the matcher back to idle. If that write is 0xAA@0x5555, it counts as the first step of a new pattern. A later write that would only have been a continuation is then treated as ordinary.
- R10: Only address bits [14:0] are compared with the command addresses. For example, 0xAAAA and 0x12AAA both act as 0x2AAA, and 0x1D555 acts as 0x5555.
- R11: With protection off, the leading 0xAA and 0x55 steps of a pattern are passed, as is a write that breaks off a partial pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_valid | input | 1 | One qualified write this cycle |
| wr_addr | input | 17 | Byte address of the write |
| wr_data | input | 8 | Data byte of the write |
| dec_valid | output | 1 | Decision for the previous cycle's write |
| dec_pass | output | 1 | 1: program the write; 0: refuse it |
| dec_addr | output | 17 | Address of the decided write |
| dec_data | output | 8 | Data of the decided write |
| prot_on | output | 1 | Protection flag |

## Verification
The hardest situation to reach is a broken sequence while protection is on. A stray write lands inside the prefix, and the bytes that follow would have completed it had the matcher not been reset. The stimulus first sets protection through a full prefix and data write. It then interleaves an ordinary write after the first step and shows that the trailing 0x55/0xA0 and the data write are all refused. Next, it repeats 0xAA@0x5555 twice in a row to show the restart counts as step one. High-order address bits are varied on command writes so that the 15-bit compare is checked together with the protected path.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
  typedef enum logic [2:0] {
    TK_OTHER = 3'd0,
    TK_AA_LO = 3'd1,
    TK_55_HI = 3'd2,
    TK_A0_LO = 3'd3,
    TK_80_LO = 3'd4,
    TK_20_LO = 3'd5
  } tok_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_P1    = 3'd1,
    ST_P2    = 3'd2,
    ST_ARMED = 3'd3,
    ST_D3    = 3'd4,
    ST_D4    = 3'd5,
    ST_D5    = 3'd6
  } seq_e;
endpackage

// File: rtl/sdp_tok_decode.sv
module sdp_tok_decode
  import sdp_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int CMP_W  = 15,
  parameter logic [CMP_W-1:0] LOC_A = 15'h5555,
  parameter logic [CMP_W-1:0] LOC_B = 15'h2AAA
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output tok_e              tok_o
);
  localparam int USE_W = (ADDR_W < CMP_W) ? ADDR_W : CMP_W;

  logic [CMP_W-1:0] key;

  generate
    if (ADDR_W >= CMP_W) begin : g_slice
      assign key = addr_i[CMP_W-1:0];
    end else begin : g_extend
      assign key = {{(CMP_W-USE_W){1'b0}}, addr_i};
    end
  endgenerate

  logic at_a;
  logic at_b;

  assign at_a = (key == LOC_A);
  assign at_b = (key == LOC_B);

  always_comb begin
    tok_o = TK_OTHER;
    if (at_a && data_i == DATA_W'(8'hAA))      tok_o = TK_AA_LO;
    else if (at_b && data_i == DATA_W'(8'h55)) tok_o = TK_55_HI;
    else if (at_a && data_i == DATA_W'(8'hA0)) tok_o = TK_A0_LO;
    else if (at_a && data_i == DATA_W'(8'h80)) tok_o = TK_80_LO;
    else if (at_a && data_i == DATA_W'(8'h20)) tok_o = TK_20_LO;
  end
endmodule

// File: rtl/sdp_seq_fsm.sv
module sdp_seq_fsm
  import sdp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic step_en,
  input  tok_e tok_i,
  input  logic prot_i,
  output logic pass_o,
  output logic set_o,
  output logic clr_o
);
  seq_e st_q;
  seq_e st_d;
  logic swallow;

  always_comb begin
    st_d    = ST_IDLE;
    swallow = 1'b0;
    set_o   = 1'b0;
    clr_o   = 1'b0;
    unique case (st_q)
      ST_IDLE: if (tok_i == TK_AA_LO) st_d = ST_P1;
      ST_P1: begin
        if (tok_i == TK_55_HI)      st_d = ST_P2;
        else if (tok_i == TK_AA_LO) st_d = ST_P1;
      end
      ST_P2: begin
        if (tok_i == TK_A0_LO) begin
          st_d    = ST_ARMED;
          swallow = 1'b1;
        end else if (tok_i == TK_80_LO) begin
          st_d    = ST_D3;
          swallow = 1'b1;
        end else if (tok_i == TK_AA_LO) begin
          st_d = ST_P1;
        end
      end
      ST_ARMED: begin
        st_d  = ST_IDLE;
        set_o = 1'b1;
      end
      ST_D3: begin
        if (tok_i == TK_AA_LO) begin
          st_d    = ST_D4;
          swallow = 1'b1;
        end
      end
      ST_D4: begin
        if (tok_i == TK_55_HI) begin
          st_d    = ST_D5;
          swallow = 1'b1;
        end else if (tok_i == TK_AA_LO) begin
          st_d = ST_P1;
        end
      end
      ST_D5: begin
        if (tok_i == TK_20_LO) begin
          st_d    = ST_IDLE;
          swallow = 1'b1;
          clr_o   = 1'b1;
        end else if (tok_i == TK_AA_LO) begin
          st_d = ST_P1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign pass_o = (st_q == ST_ARMED) || (!prot_i && !swallow);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else if (step_en) begin
      st_q <= st_d;
    end
  end
endmodule

// File: rtl/sdp_seq_guard.sv
module sdp_seq_guard
  import sdp_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int CMP_W  = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              dec_valid,
  output logic              dec_pass,
  output logic [ADDR_W-1:0] dec_addr,
  output logic [DATA_W-1:0] dec_data,
  output logic              prot_on
);
  logic [1:0] rst_pipe;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  tok_e tok;
  logic pass_c;
  logic set_c;
  logic clr_c;

  sdp_tok_decode #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .CMP_W (CMP_W)
  ) u_dec (
    .addr_i(wr_addr),
    .data_i(wr_data),
    .tok_o (tok)
  );

  sdp_seq_fsm u_fsm (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .step_en(wr_valid),
    .tok_i  (tok),
    .prot_i (prot_on),
    .pass_o (pass_c),
    .set_o  (set_c),
    .clr_o  (clr_c)
  );

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      dec_valid <= 1'b0;
      dec_pass  <= 1'b0;
      dec_addr  <= '0;
      dec_data  <= '0;
      prot_on   <= 1'b0;
    end else begin
      dec_valid <= wr_valid;
      dec_pass  <= wr_valid && pass_c;
      if (wr_valid) begin
        dec_addr <= wr_addr;
        dec_data <= wr_data;
      end
      if (wr_valid && set_c)      prot_on <= 1'b1;
      else if (wr_valid && clr_c) prot_on <= 1'b0;
    end
  end
endmodule

// File: rtl/sdp_seq_guard_chk.sv
module sdp_seq_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_valid,
  input logic dec_valid,
  input logic dec_pass,
  input logic prot_on
);
  AST_DEC_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> dec_valid); // R2
  AST_NO_SPURIOUS_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> !dec_valid); // R2
  AST_PASS_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    dec_pass |-> dec_valid); // R2
  AST_PROT_RISE_ON_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prot_on) |-> (dec_valid && dec_pass)); // R4
  AST_PROT_FALL_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prot_on) |-> (dec_valid && !dec_pass)); // R8
  AST_PROT_STABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> $stable(prot_on)); // R5
endmodule

bind sdp_seq_guard sdp_seq_guard_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_valid (wr_valid),
  .dec_valid(dec_valid),
  .dec_pass (dec_pass),
  .prot_on  (prot_on)
);

// File: tb/sdp_seq_guard_tb.sv
module sdp_seq_guard_tb;
  logic        clk;
  logic        rst_n;
  logic        wr_valid;
  logic [16:0] wr_addr;
  logic [7:0]  wr_data;
  logic        dec_valid;
  logic        dec_pass;
  logic [16:0] dec_addr;
  logic [7:0]  dec_data;
  logic        prot_on;

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  typedef struct {
    logic [16:0] a;
    logic [7:0]  d;
    logic        pass;
    logic        prot;
    string       tag;
  } exp_t;

  exp_t q[$];

  sdp_seq_guard u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .dec_valid(dec_valid),
    .dec_pass (dec_pass),
    .dec_addr (dec_addr),
    .dec_data (dec_data),
    .prot_on  (prot_on)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic wr(input logic [16:0] a, input logic [7:0] d,
                    input logic p, input logic pr, input string tag);
    exp_t e;
    @(negedge clk);
    wr_valid = 1'b1;
    wr_addr  = a;
    wr_data  = d;
    e.a = a; e.d = d; e.pass = p; e.prot = pr; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && !ended && dec_valid) begin
      total++;
      if (q.size() == 0) begin
        bad++;
        $display("FAIL R2 decision without write: actual dec_valid=1 expected 0");
      end else begin
        exp_t e;
        e = q.pop_front();
        if (dec_pass !== e.pass || prot_on !== e.prot ||
            dec_addr !== e.a || dec_data !== e.d) begin
          bad++;
          $display("FAIL %s: actual pass=%0b prot=%0b addr=%h data=%h expected pass=%0b prot=%0b addr=%h data=%h",
                   e.tag, dec_pass, prot_on, dec_addr, dec_data, e.pass, e.prot, e.a, e.d);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_valid = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    total++;
    if (prot_on !== 1'b0 || dec_valid !== 1'b0) begin
      bad++;
      $display("FAIL R1: actual prot=%0b valid=%0b expected 0 0", prot_on, dec_valid);
    end

    wr(17'h00100, 8'h3C, 1, 0, "R3 plain write");
    wr(17'h05555, 8'hAA, 1, 0, "R11 AA step passes");
    wr(17'h02AAA, 8'h55, 1, 0, "R11 55 step passes");
    wr(17'h05555, 8'hA0, 0, 0, "R5 prefix alone");
    wr(17'h00200, 8'h11, 1, 1, "R4 data after prefix");
    wr(17'h00300, 8'h22, 0, 1, "R6 unprefixed blocked");
    wr(17'h05555, 8'hAA, 0, 1, "R6 AA step");
    wr(17'h0AAAA, 8'h55, 0, 1, "R10 AAAA as 2AAA");
    wr(17'h05555, 8'hA0, 0, 1, "R4 A0 refused");
    wr(17'h00400, 8'h33, 1, 1, "R7 one write through");
    wr(17'h00401, 8'h34, 0, 1, "R7 second blocked");
    wr(17'h05555, 8'hAA, 0, 1, "R9 step one");
    wr(17'h00500, 8'h77, 0, 1, "R9 break");
    wr(17'h02AAA, 8'h55, 0, 1, "R9 stale 55");
    wr(17'h05555, 8'hA0, 0, 1, "R9 stale A0");
    wr(17'h00600, 8'h44, 0, 1, "R9 not armed");
    wr(17'h05555, 8'hAA, 0, 1, "R9 first AA");
    wr(17'h05555, 8'hAA, 0, 1, "R9 restart AA");
    wr(17'h02AAA, 8'h55, 0, 1, "R9 55");
    wr(17'h05555, 8'hA0, 0, 1, "R9 A0");
    wr(17'h00700, 8'h55, 1, 1, "R9 restart armed");
    wr(17'h1D555, 8'hAA, 0, 1, "R10 high bits AA");
    wr(17'h12AAA, 8'h55, 0, 1, "R10 high bits 55");
    wr(17'h15555, 8'hA0, 0, 1, "R10 high bits A0");
    wr(17'h00780, 8'h66, 1, 1, "R10 armed by aliased");
    wr(17'h05555, 8'hAA, 0, 1, "R8 d1");
    wr(17'h02AAA, 8'h55, 0, 1, "R8 d2");
    wr(17'h05555, 8'h80, 0, 1, "R8 d3");
    wr(17'h05555, 8'hAA, 0, 1, "R8 d4");
    wr(17'h02AAA, 8'h55, 0, 1, "R8 d5");
    wr(17'h05555, 8'h20, 0, 0, "R8 d6 clears");
    wr(17'h00800, 8'h99, 1, 0, "R8 write after disable");
    wr(17'h05555, 8'hAA, 1, 0, "R11 d1 off");
    wr(17'h02AAA, 8'h55, 1, 0, "R11 d2 off");
    wr(17'h05555, 8'h80, 0, 0, "R8 d3 off refused");
    wr(17'h05555, 8'hAA, 0, 0, "R8 d4 off refused");
    wr(17'h02AAA, 8'h55, 0, 0, "R8 d5 off refused");
    wr(17'h05555, 8'h20, 0, 0, "R8 d6 off refused");
    wr(17'h05555, 8'hAA, 1, 0, "R11 AA off");
    wr(17'h00900, 8'h5A, 1, 0, "R11 break off passes");
    wr(17'h02AAA, 8'h55, 1, 0, "R9 stale 55 off");
    wr(17'h00A00, 8'hA5, 1, 0, "R3 final plain");

    repeat (4) @(negedge clk);
    total++;
    if (q.size() != 0) begin
      bad++;
      $display("FAIL R2 missing decisions: actual pending=%0d expected 0", q.size());
    end
    ended = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule